// File: doc/BRIEF.md
# AXI-to-PCI Address Window Translator

This block maps 32-bit host addresses from the AXI side onto a 40-bit PCI fabric address space. Six programmable windows each describe a range of host addresses by a start address and a length counted in 4 KiB pages. Each window also carries a fabric base that places the range anywhere in the 40-bit target space, plus a flag that marks the window as memory type. A narrow write-only configuration port programs the windows, the interrupt enable and the write-one-to-clear interrupt status.

Lookups arrive on a valid/ready stream, one host address per transfer. The answer appears one cycle after acceptance on a registered valid/ready result stream. It carries a hit flag, the translated address, the index of the matching window and the memory-type flag. A single result register sits between the two streams. A lookup is accepted whenever that register is empty or is being drained in the same cycle, so back-pressure on the result side stalls the lookup side with no added delay. An address that falls in no window returns a miss and latches a decode-error status bit, which drives an interrupt output when it is enabled.

Top module: `axi_window_xlate`

## Requirements
- R1: After reset, rs_valid and dec_irq are 0, lk_ready is 1, and every window has zero size, so the first lookup returns a miss.
- R2: Configuration writes go to byte address 16*w + field for window w (0..5). Field 0x0 is the 32-bit host start, 0x4 is the size in pages (bits 19:0), and 0x8 is the fabric base. Address 0x60 bit 6 is the decode-error interrupt enable, and address 0x64 bit 6 is the decode-error status, which is cleared by writing 1.
- R3: An address hits window w when start <= addr < start + pages*4096. The translated address is then (fabric base bits 31:4 shifted left by 12) + (addr - start), 40 bits wide.
- R4: A window with a size of 0 pages never produces a hit, whatever its start.
- R5: When several windows hit, the lowest-numbered one is reported, and rs_win gives its index.
- R6: A miss returns rs_hit=0, rs_addr=0, rs_win=0, rs_mem=0 and sets the decode-error status bit in the same cycle that the result becomes valid.
- R7: dec_irq is 1 exactly when both the status bit and the enable bit are set. Writing 1 to bit 6 of 0x64 clears the status, and a miss in that same cycle keeps it set.
- R8: The result is valid on the clock edge that accepts the lookup (lk_ready = !rs_valid || rs_ready). While rs_valid=1 and rs_ready=0, every result output holds still and lk_ready is 0.
- R9: rs_mem equals bit 0 of the hit window's fabric base, and fabric-base bits 3:1 have no effect on the translation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 8 | Configuration byte address |
| cfg_wdata | input | 32 | Configuration write data |
| lk_valid | input | 1 | Lookup address valid |
| lk_ready | output | 1 | Lookup accepted when high with lk_valid |
| lk_addr | input | 32 | Host address to translate |
| rs_valid | output | 1 | Result valid |
| rs_ready | input | 1 | Result consumer ready |
| rs_hit | output | 1 | Address fell in a window |
| rs_addr | output | 40 | Translated fabric address |
| rs_win | output | 3 | Index of the winning window |
| rs_mem | output | 1 | Winning window is memory type |
| dec_irq | output | 1 | Decode-error interrupt |

## Verification
The hardest case to reach from the ports is a result held under back-pressure while the next lookup waits. The bench forces rs_ready low across an accepted lookup and checks, over several cycles, that lk_ready stays low and the held translation stays unchanged. It then runs a burst of lookups under a periodic stall pattern. Priority among overlapping windows is reached by reprogramming windows so that they overlap, first at a higher index and then at index 0. The exact edges of each range are probed one byte inside and one byte outside.

// File: rtl/xlate_pkg.sv
package xlate_pkg;
  localparam int AXI_AW      = 32;
  localparam int FAB_AW      = 40;
  localparam int PG_SH       = 12;
  localparam int CFG_DW      = 32;
  localparam int PG_AW       = AXI_AW - PG_SH;
  localparam int FAB_PG_W    = FAB_AW - PG_SH;
  localparam int DEC_ERR_BIT = 6;

  typedef struct packed {
    logic [AXI_AW-1:0]   start;
    logic [PG_AW-1:0]    pages;
    logic [FAB_PG_W-1:0] fab_pg;
    logic                is_mem;
  } win_cfg_t;
endpackage

// File: rtl/xlate_regs.sv
module xlate_regs
  import xlate_pkg::*;
#(
  parameter int NUM_WIN = 6,
  parameter int CFG_AW  = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cfg_we,
  input  logic [CFG_AW-1:0]    cfg_addr,
  input  logic [CFG_DW-1:0]    cfg_wdata,
  input  logic                 miss_evt,
  output win_cfg_t [NUM_WIN-1:0] win_o,
  output logic                 dec_status,
  output logic                 dec_irq
);
  localparam int SEL_W = CFG_AW - 4;
  localparam logic [SEL_W-1:0] CTRL_SEL = SEL_W'(NUM_WIN);
  localparam logic [1:0] F_START = 2'd0;
  localparam logic [1:0] F_PAGES = 2'd1;
  localparam logic [1:0] F_FAB   = 2'd2;
  localparam logic [1:0] F_EN    = 2'd0;
  localparam logic [1:0] F_STAT  = 2'd1;

  logic [SEL_W-1:0] sel;
  logic [1:0]       fld;
  logic             en_q, stat_q, clr_req;
  logic             cfg_unused;

  assign sel        = cfg_addr[CFG_AW-1:4];
  assign fld        = cfg_addr[3:2];
  assign cfg_unused = ^{cfg_addr[1:0], cfg_wdata};
  assign clr_req    = cfg_we && (sel == CTRL_SEL) && (fld == F_STAT) && cfg_wdata[DEC_ERR_BIT];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      win_o  <= '0;
      en_q   <= 1'b0;
      stat_q <= 1'b0;
    end else begin
      for (int w = 0; w < NUM_WIN; w++) begin
        if (cfg_we && sel == SEL_W'(w)) begin
          case (fld)
            F_START: win_o[w].start <= cfg_wdata[AXI_AW-1:0];
            F_PAGES: win_o[w].pages <= cfg_wdata[PG_AW-1:0];
            F_FAB: begin
              win_o[w].fab_pg <= cfg_wdata[CFG_DW-1:CFG_DW-FAB_PG_W];
              win_o[w].is_mem <= cfg_wdata[0];
            end
            default: ;
          endcase
        end
      end
      if (cfg_we && sel == CTRL_SEL && fld == F_EN)
        en_q <= cfg_wdata[DEC_ERR_BIT];
      // a new miss takes precedence over a clear in the same cycle
      stat_q <= miss_evt | (stat_q & ~clr_req);
    end
  end

  assign dec_status = stat_q;
  assign dec_irq    = stat_q & en_q;
endmodule

// File: rtl/xlate_win_match.sv
module xlate_win_match
  import xlate_pkg::*;
(
  input  win_cfg_t          cfg,
  input  logic [AXI_AW-1:0] addr,
  output logic              hit,
  output logic [FAB_AW-1:0] xaddr
);
  logic [AXI_AW:0] diff;

  assign diff  = {1'b0, addr} - {1'b0, cfg.start};
  // no borrow means addr >= start; page count bounds the offset
  assign hit   = !diff[AXI_AW] && (diff[AXI_AW-1:PG_SH] < cfg.pages);
  assign xaddr = {cfg.fab_pg, {PG_SH{1'b0}}} + {{(FAB_AW-AXI_AW){1'b0}}, diff[AXI_AW-1:0]};
endmodule

// File: rtl/xlate_prio.sv
module xlate_prio
  import xlate_pkg::*;
#(
  parameter int NUM_WIN = 6,
  parameter int WIN_W   = 3
) (
  input  logic [NUM_WIN-1:0]              hits,
  input  logic [NUM_WIN-1:0][FAB_AW-1:0]  xaddrs,
  input  logic [NUM_WIN-1:0]              mems,
  output logic                            any,
  output logic [WIN_W-1:0]                idx,
  output logic [FAB_AW-1:0]               addr,
  output logic                            mem
);
  always_comb begin
    any  = 1'b0;
    idx  = '0;
    addr = '0;
    mem  = 1'b0;
    // scan downward so the lowest hitting index is written last
    for (int w = NUM_WIN - 1; w >= 0; w--) begin
      if (hits[w]) begin
        any  = 1'b1;
        idx  = WIN_W'(w);
        addr = xaddrs[w];
        mem  = mems[w];
      end
    end
  end
endmodule

// File: rtl/axi_window_xlate.sv
module axi_window_xlate
  import xlate_pkg::*;
#(
  parameter int NUM_WIN = 6,
  parameter int CFG_AW  = 8,
  localparam int WIN_W  = (NUM_WIN > 1) ? $clog2(NUM_WIN) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [CFG_AW-1:0] cfg_addr,
  input  logic [CFG_DW-1:0] cfg_wdata,
  input  logic              lk_valid,
  output logic              lk_ready,
  input  logic [AXI_AW-1:0] lk_addr,
  output logic              rs_valid,
  input  logic              rs_ready,
  output logic              rs_hit,
  output logic [FAB_AW-1:0] rs_addr,
  output logic [WIN_W-1:0]  rs_win,
  output logic              rs_mem,
  output logic              dec_irq
);
  win_cfg_t [NUM_WIN-1:0]             win;
  logic [NUM_WIN-1:0]                 hits, mems;
  logic [NUM_WIN-1:0][FAB_AW-1:0]     xaddrs;
  logic                               any, sel_mem, accept, miss_evt, dec_status;
  logic [WIN_W-1:0]                   sel_idx;
  logic [FAB_AW-1:0]                  sel_addr;

  assign lk_ready = !rs_valid || rs_ready;
  assign accept   = lk_valid && lk_ready;
  assign miss_evt = accept && !any;

  xlate_regs #(.NUM_WIN(NUM_WIN), .CFG_AW(CFG_AW)) u_regs (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .miss_evt(miss_evt), .win_o(win),
    .dec_status(dec_status), .dec_irq(dec_irq)
  );

  for (genvar w = 0; w < NUM_WIN; w++) begin : g_win
    xlate_win_match u_match (
      .cfg(win[w]), .addr(lk_addr), .hit(hits[w]), .xaddr(xaddrs[w])
    );
    assign mems[w] = win[w].is_mem;
  end

  xlate_prio #(.NUM_WIN(NUM_WIN), .WIN_W(WIN_W)) u_prio (
    .hits(hits), .xaddrs(xaddrs), .mems(mems),
    .any(any), .idx(sel_idx), .addr(sel_addr), .mem(sel_mem)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rs_valid <= 1'b0;
      rs_hit   <= 1'b0;
      rs_addr  <= '0;
      rs_win   <= '0;
      rs_mem   <= 1'b0;
    end else if (accept) begin
      rs_valid <= 1'b1;
      rs_hit   <= any;
      rs_addr  <= any ? sel_addr : '0;
      rs_win   <= any ? sel_idx : '0;
      rs_mem   <= any & sel_mem;
    end else if (rs_ready) begin
      rs_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/xlate_chk.sv
module xlate_chk #(
  parameter int NUM_WIN = 6,
  parameter int WIN_W   = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              lk_valid,
  input logic              lk_ready,
  input logic              rs_valid,
  input logic              rs_ready,
  input logic              rs_hit,
  input logic [39:0]       rs_addr,
  input logic [WIN_W-1:0]  rs_win,
  input logic              rs_mem,
  input logic              dec_status
);
  AST_ACCEPT_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_valid && lk_ready) |=> rs_valid); // R8
  AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (rs_valid && !rs_ready) |=> (rs_valid && $stable(rs_addr) && $stable(rs_hit) && $stable(rs_win) && $stable(rs_mem))); // R8
  AST_MISS_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
    (rs_valid && !rs_hit) |-> (rs_addr == '0 && rs_win == '0 && !rs_mem)); // R6
  AST_WIN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (rs_valid && rs_hit) |-> (int'(rs_win) < NUM_WIN)); // R5
  AST_MISS_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(lk_valid && lk_ready) && rs_valid && !rs_hit) |-> dec_status); // R6
endmodule

bind axi_window_xlate xlate_chk #(.NUM_WIN(NUM_WIN), .WIN_W(WIN_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .lk_valid(lk_valid), .lk_ready(lk_ready),
  .rs_valid(rs_valid), .rs_ready(rs_ready), .rs_hit(rs_hit),
  .rs_addr(rs_addr), .rs_win(rs_win), .rs_mem(rs_mem), .dec_status(dec_status)
);

// File: tb/tb_axi_window_xlate.sv
module tb_axi_window_xlate;
  localparam int NW = 6;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [7:0]  cfg_addr = '0;
  logic [31:0] cfg_wdata = '0;
  logic        lk_valid = 1'b0;
  logic        lk_ready;
  logic [31:0] lk_addr = '0;
  logic        rs_valid;
  logic        rs_ready = 1'b1;
  logic        rs_hit;
  logic [39:0] rs_addr;
  logic [2:0]  rs_win;
  logic        rs_mem;
  logic        dec_irq;

  axi_window_xlate dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .lk_valid(lk_valid), .lk_ready(lk_ready),
    .lk_addr(lk_addr), .rs_valid(rs_valid), .rs_ready(rs_ready),
    .rs_hit(rs_hit), .rs_addr(rs_addr), .rs_win(rs_win), .rs_mem(rs_mem),
    .dec_irq(dec_irq)
  );

  always #2 clk = ~clk;

  typedef struct {
    logic        hit;
    logic [39:0] addr;
    logic [2:0]  win;
    logic        mem;
    string       tag;
  } exp_t;

  exp_t        q[$];
  logic [31:0] st[NW];
  logic [19:0] sz[NW];
  logic [31:0] fb[NW];
  int          checks = 0;
  int          errors = 0;
  bit          done = 0;
  bit          hold = 0;
  bit          stall_en = 0;
  int          cyc = 0;

  initial for (int w = 0; w < NW; w++) begin st[w] = '0; sz[w] = '0; fb[w] = '0; end

  function automatic exp_t model(input logic [31:0] a);
    exp_t e;
    longint unsigned lo, hi, base;
    e.hit = 1'b0; e.addr = '0; e.win = '0; e.mem = 1'b0; e.tag = "";
    for (int w = NW - 1; w >= 0; w--) begin
      lo   = longint'(st[w]);
      hi   = lo + (longint'(sz[w]) << 12);
      base = (longint'(fb[w]) >> 4) << 12;
      if (sz[w] != 0 && longint'(a) >= lo && longint'(a) < hi) begin
        e.hit  = 1'b1;
        e.win  = 3'(w);
        e.mem  = fb[w][0];
        e.addr = 40'(base + (longint'(a) - lo));
      end
    end
    return e;
  endfunction

  task automatic check(input bit ok, input string msg, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", msg, act, exp);
    end
  endtask

  task automatic cfg_wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic win_set(input int w, input logic [31:0] s, input logic [31:0] p, input logic [31:0] f);
    cfg_wr(8'(w * 16), s);      st[w] = s;
    cfg_wr(8'(w * 16 + 4), p);  sz[w] = p[19:0];
    cfg_wr(8'(w * 16 + 8), f);  fb[w] = f;
  endtask

  task automatic lookup(input logic [31:0] a, input string tag);
    exp_t e;
    e = model(a);
    e.tag = tag;
    q.push_back(e);
    @(negedge clk);
    lk_valid = 1'b1; lk_addr = a;
    while (!lk_ready) @(negedge clk);
    @(posedge clk);
    #1 lk_valid = 1'b0;
  endtask

  task automatic drain();
    while (q.size() != 0) @(negedge clk);
    @(negedge clk);
  endtask

  // result consumer: changes only just after a rising edge
  always @(posedge clk) begin
    #1;
    cyc++;
    rs_ready = hold ? 1'b0 : (stall_en ? (cyc % 3 != 0) : 1'b1);
  end

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n && rs_valid && rs_ready) begin
      if (q.size() == 0) begin
        check(1'b0, "R8 unexpected result", longint'(rs_addr), 0);
      end else begin
        exp_t e;
        e = q.pop_front();
        check(rs_hit == e.hit, {e.tag, " hit"}, longint'(rs_hit), longint'(e.hit));
        check(rs_addr == e.addr, {e.tag, " addr"}, longint'(rs_addr), longint'(e.addr));
        check(rs_win == e.win, {e.tag, " win"}, longint'(rs_win), longint'(e.win));
        check(rs_mem == e.mem, {e.tag, " mem"}, longint'(rs_mem), longint'(e.mem));
      end
    end
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [39:0] held;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(rs_valid == 1'b0, "R1 rs_valid after reset", longint'(rs_valid), 0);
    check(dec_irq == 1'b0, "R1 dec_irq after reset", longint'(dec_irq), 0);
    check(lk_ready == 1'b1, "R1 lk_ready after reset", longint'(lk_ready), 1);
    lookup(32'h1000_4000, "R1 unprogrammed miss");
    drain();

    // R2 programming through the map
    win_set(0, 32'h1000_4000, 32'h100,   32'hFDFF_0000);
    win_set(1, 32'h1010_4000, 32'h100,   32'hFE10_0000);
    win_set(2, 32'h1040_0000, 32'h10,    32'hFDFC_0000);
    win_set(3, 32'h3000_0000, 32'h8000,  32'h3000_000F);
    win_set(4, 32'h2000_0000, 32'h10000, 32'h2000_0001);
    win_set(5, 32'h5000_0000, 32'h0,     32'h5000_0001);

    lookup(32'h1000_4000, "R2 win0 start");
    lookup(32'h1010_3FFF, "R3 win0 last byte");
    lookup(32'h1010_4000, "R3 win1 first byte");
    lookup(32'h1000_3FFF, "R3 below win0 miss");
    lookup(32'h1041_0000, "R3 past win2 miss");
    lookup(32'h1040_0123, "R3 win2 io");
    lookup(32'h2ABC_DEF0, "R3 win4 mid");
    lookup(32'h3000_0010, "R9 win3 mem type");
    lookup(32'h5000_0000, "R4 zero size miss");
    drain();

    // R7 interrupt gating and clear
    check(dec_irq == 1'b0, "R7 irq masked", longint'(dec_irq), 0);
    cfg_wr(8'h60, 32'h40);
    @(negedge clk);
    check(dec_irq == 1'b1, "R7 irq enabled", longint'(dec_irq), 1);
    cfg_wr(8'h64, 32'h40);
    @(negedge clk);
    check(dec_irq == 1'b0, "R7 irq cleared", longint'(dec_irq), 0);
    lookup(32'hF000_0000, "R6 miss sets status");
    drain();
    check(dec_irq == 1'b1, "R6 status after miss", longint'(dec_irq), 1);
    cfg_wr(8'h64, 32'h40);
    @(negedge clk);
    check(dec_irq == 1'b0, "R7 clear again", longint'(dec_irq), 0);

    // R5 overlap priority
    win_set(5, 32'h2000_0000, 32'h1, 32'h6000_0000);
    lookup(32'h2000_0100, "R5 win4 beats win5");
    win_set(0, 32'h2000_0000, 32'h1, 32'h7000_0000);
    lookup(32'h2000_0100, "R5 win0 beats all");
    drain();

    // R8 hold under back-pressure
    hold = 1'b1;
    @(posedge clk);
    lookup(32'h1040_0020, "R8 held result");
    @(negedge clk);
    check(rs_valid == 1'b1, "R8 valid after accept", longint'(rs_valid), 1);
    check(lk_ready == 1'b0, "R8 ready low while held", longint'(lk_ready), 0);
    held = rs_addr;
    check(held == 40'hFD_FC00_0020, "R8 held addr", longint'(held), longint'(40'hFD_FC00_0020));
    repeat (3) @(negedge clk);
    check(rs_valid == 1'b1 && rs_addr == held, "R8 stable while stalled", longint'(rs_addr), longint'(held));
    hold = 1'b0;
    drain();

    stall_en = 1'b1;
    for (int i = 0; i < 12; i++)
      lookup(32'h1000_0000 + 32'(i) * 32'h0008_1000, "R8 stalled burst");
    drain();
    stall_en = 1'b0;
    drain();

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule